// File: doc/BRIEF.md
# Virtual CPU Interrupt Interface

This block is the guest-facing CPU interface of a virtualised interrupt controller. A hypervisor fills a small bank of list entries. Each entry names a virtual interrupt, its physical partner, a coarse priority, pending and active flags and a hardware-link flag. The guest then talks to the block over a simple register bus. It reads to acknowledge the best pending interrupt, writes an end-of-interrupt (EOI) to drop its running priority, and writes a deactivate to retire an interrupt.

Running priority is tracked with a bitmap that has one bit per priority group. A control bit selects split mode. In split mode, dropping the priority and retiring the interrupt are separate guest actions. EOI and deactivate writes can name an ID that no list entry holds; these are handled by fixed rules. Depending on the mode, such a write still drops the priority, bumps a wrapping EOI counter, or does nothing. When a hardware-linked entry is retired, the block pulses the physical ID towards the distributor.

Top module: `vcpu_irq_if`

## Requirements
- R1: After reset the priority bitmap is zero, the running priority is 0xFF, the EOI counter is 0, split mode is off, every list entry reads as zero and no forward pulse is active.
- R2: A list entry is written and read as one word in this layout: bits [9:0] virtual ID, [19:10] physical ID, [24:20] stored priority, bit 25 pending, bit 26 active, bit 27 hardware-linked. An entry that is neither pending nor active is invalid.
- R3: Bus operation codes are: 0 acknowledge (read), 1 EOI (write, ID in wdata[9:0]), 2 deactivate (write, ID in wdata[9:0]), 3 control (write or read, bit 0 is split mode). Read data appears on bus_rdata the cycle after the request.
- R4: The full 8-bit priority is the stored value shifted left by 3. Bitmap bit n stands for group n. The running priority is 8 times the lowest set bit, or 0xFF when the bitmap is zero.
- R5: Acknowledge returns the virtual ID of the pending entry with the lowest full priority value. That value must be strictly below the running priority, and ties go to the lowest index. If no entry qualifies, acknowledge returns 1023 and changes no state.
- R6: A successful acknowledge leaves the chosen entry active and not pending in a single step, and sets the bitmap bit of its priority.
- R7: With split mode off, an EOI that names a valid entry clears the lowest set bitmap bit and clears that entry's active flag. The EOI counter does not change.
- R8: With split mode off, an EOI that names no valid entry clears the lowest set bitmap bit and increments the EOI counter. If the bitmap is already zero, it has no effect.
- R9: With split mode on, an EOI clears the lowest set bitmap bit if one is set. It never touches list entries and never changes the counter.
- R10: With split mode on, a deactivate that names a valid entry clears its active flag. One that names no valid entry increments the EOI counter.
- R11: With split mode off, every deactivate write is ignored.
- R12: When a write clears the active flag of a hardware-linked entry, hw_deact_o is high for exactly one cycle, in the cycle after the write, with that entry's physical ID on hw_deact_id_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus request strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_op | input | 2 | Operation code |
| bus_wdata | input | 10 | Write data (interrupt ID or control) |
| bus_rdata | output | 10 | Read data, registered |
| lr_we | input | 1 | Hypervisor list-entry write strobe |
| lr_idx | input | 2 | List entry index for write and read |
| lr_wdata | input | 28 | List entry write word |
| lr_rdata | output | 28 | List entry read word (combinational) |
| apr_o | output | 32 | Active-priority bitmap |
| run_prio_o | output | 8 | Running priority |
| eoi_cnt_o | output | 5 | EOI counter, wraps |
| split_eoi_o | output | 1 | Split mode bit |
| hw_deact_o | output | 1 | Physical deactivate pulse |
| hw_deact_id_o | output | 10 | Physical ID that goes with the pulse |

## Verification
The bench sets up list entries with tied priorities and one invalid entry that has the best priority, to check acknowledge selection. It expects the tie to go to the lower index and the invalid entry to be skipped. Acknowledging an entry at exactly the running priority must return 1023; a `<=` comparison would instead return a nested interrupt.

It walks unmatched EOI and deactivate writes through both modes, and again with the bitmap empty. A design with the mode rules swapped would bump the counter on the wrong operation, or drop the priority where nothing should happen. Finally, it deactivates hardware-linked entries in each mode. A missing, misplaced or stretched forward pulse, or a pulse that fires on a split-mode EOI, shows up directly on hw_deact_o.

// File: rtl/vcpu_irq_if.sv
module vcpu_irq_if #(
  parameter int NUM_LR = 4,
  parameter int ID_W   = 10,
  parameter int PRIO_W = 5,
  parameter int CNT_W  = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bus_valid,
  input  logic                          bus_write,
  input  logic [1:0]                    bus_op,
  input  logic [ID_W-1:0]               bus_wdata,
  output logic [ID_W-1:0]               bus_rdata,
  input  logic                          lr_we,
  input  logic [$clog2(NUM_LR)-1:0]     lr_idx,
  input  logic [2*ID_W+PRIO_W+2:0]      lr_wdata,
  output logic [2*ID_W+PRIO_W+2:0]      lr_rdata,
  output logic [(1<<PRIO_W)-1:0]        apr_o,
  output logic [7:0]                    run_prio_o,
  output logic [CNT_W-1:0]              eoi_cnt_o,
  output logic                          split_eoi_o,
  output logic                          hw_deact_o,
  output logic [ID_W-1:0]               hw_deact_id_o
);
  localparam int IDX_W   = $clog2(NUM_LR);
  localparam int NAPR    = 1 << PRIO_W;
  localparam int SHIFT   = 8 - PRIO_W;
  localparam int PID_LO  = ID_W;
  localparam int PRI_LO  = 2 * ID_W;
  localparam int PEND_B  = 2 * ID_W + PRIO_W;
  localparam int ACT_B   = PEND_B + 1;
  localparam int HW_B    = PEND_B + 2;
  localparam logic [1:0] OP_ACK = 2'd0;
  localparam logic [1:0] OP_EOI = 2'd1;
  localparam logic [1:0] OP_DIR = 2'd2;
  localparam logic [1:0] OP_CTL = 2'd3;
  localparam logic [ID_W-1:0] SPURIOUS = '1;

  logic [NUM_LR-1:0][ID_W-1:0]   vid_q, pid_q;
  logic [NUM_LR-1:0][PRIO_W-1:0] pri_q;
  logic [NUM_LR-1:0]             pend_q, act_q, hw_q;
  logic [NAPR-1:0]               apr_q;
  logic [CNT_W-1:0]              cnt_q;
  logic                          split_q;

  logic              apr_any;
  logic [PRIO_W-1:0] apr_lo;
  logic              best_ok, ack_hit;
  logic [IDX_W-1:0]  best_idx;
  logic [7:0]        best_pri;
  logic              mt_ok;
  logic [IDX_W-1:0]  mt_idx;

  assign apr_any     = |apr_q;
  assign apr_o       = apr_q;
  assign eoi_cnt_o   = cnt_q;
  assign split_eoi_o = split_q;
  assign run_prio_o  = apr_any ? {apr_lo, {SHIFT{1'b0}}} : 8'hFF;
  assign ack_hit     = best_ok && (best_pri < run_prio_o);

  assign lr_rdata = {hw_q[lr_idx], act_q[lr_idx], pend_q[lr_idx],
                     pri_q[lr_idx], pid_q[lr_idx], vid_q[lr_idx]};

  always_comb begin
    apr_lo = '0;
    for (int i = NAPR - 1; i >= 0; i--)
      if (apr_q[i]) apr_lo = i[PRIO_W-1:0];
  end

  always_comb begin
    best_ok  = 1'b0;
    best_idx = '0;
    best_pri = 8'hFF;
    for (int i = NUM_LR - 1; i >= 0; i--)
      if (pend_q[i] && ({pri_q[i], {SHIFT{1'b0}}} <= best_pri)) begin
        best_ok  = 1'b1;
        best_idx = i[IDX_W-1:0];
        best_pri = {pri_q[i], {SHIFT{1'b0}}};
      end
  end

  always_comb begin
    mt_ok  = 1'b0;
    mt_idx = '0;
    for (int i = NUM_LR - 1; i >= 0; i--)
      if ((pend_q[i] || act_q[i]) && (vid_q[i] == bus_wdata)) begin
        mt_ok  = 1'b1;
        mt_idx = i[IDX_W-1:0];
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vid_q         <= '0;
      pid_q         <= '0;
      pri_q         <= '0;
      pend_q        <= '0;
      act_q         <= '0;
      hw_q          <= '0;
      apr_q         <= '0;
      cnt_q         <= '0;
      split_q       <= 1'b0;
      bus_rdata     <= '0;
      hw_deact_o    <= 1'b0;
      hw_deact_id_o <= '0;
    end else begin
      hw_deact_o <= 1'b0;
      if (bus_valid && !bus_write) begin
        if (bus_op == OP_ACK) begin
          if (ack_hit) begin
            act_q[best_idx]         <= 1'b1;
            pend_q[best_idx]        <= 1'b0;
            apr_q[pri_q[best_idx]]  <= 1'b1;
            bus_rdata               <= vid_q[best_idx];
          end else begin
            bus_rdata <= SPURIOUS;
          end
        end else if (bus_op == OP_CTL) begin
          bus_rdata <= {{(ID_W-1){1'b0}}, split_q};
        end else begin
          bus_rdata <= '0;
        end
      end
      if (bus_valid && bus_write) begin
        case (bus_op)
          OP_EOI: begin
            if (apr_any) apr_q[apr_lo] <= 1'b0;
            if (!split_q) begin
              if (mt_ok) begin
                act_q[mt_idx] <= 1'b0;
                if (hw_q[mt_idx] && act_q[mt_idx]) begin
                  hw_deact_o    <= 1'b1;
                  hw_deact_id_o <= pid_q[mt_idx];
                end
              end else if (apr_any) begin
                cnt_q <= cnt_q + 1'b1;
              end
            end
          end
          OP_DIR: begin
            if (split_q) begin
              if (mt_ok) begin
                act_q[mt_idx] <= 1'b0;
                if (hw_q[mt_idx] && act_q[mt_idx]) begin
                  hw_deact_o    <= 1'b1;
                  hw_deact_id_o <= pid_q[mt_idx];
                end
              end else begin
                cnt_q <= cnt_q + 1'b1;
              end
            end
          end
          OP_CTL:  split_q <= bus_wdata[0];
          default: ;
        endcase
      end
      if (lr_we) begin
        vid_q[lr_idx]  <= lr_wdata[ID_W-1:0];
        pid_q[lr_idx]  <= lr_wdata[PID_LO +: ID_W];
        pri_q[lr_idx]  <= lr_wdata[PRI_LO +: PRIO_W];
        pend_q[lr_idx] <= lr_wdata[PEND_B];
        act_q[lr_idx]  <= lr_wdata[ACT_B];
        hw_q[lr_idx]   <= lr_wdata[HW_B];
      end
    end
  end
endmodule

module vcpu_irq_if_chk #(
  parameter int ID_W   = 10,
  parameter int PRIO_W = 5,
  parameter int CNT_W  = 5
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bus_valid,
  input logic                   bus_write,
  input logic [1:0]             bus_op,
  input logic [ID_W-1:0]        bus_rdata,
  input logic [(1<<PRIO_W)-1:0] apr_o,
  input logic [CNT_W-1:0]       eoi_cnt_o,
  input logic                   hw_deact_o
);
  a_r8_cnt_steps_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_cnt_o != $past(eoi_cnt_o)) |->
      ($past(bus_valid && bus_write) && eoi_cnt_o == $past(eoi_cnt_o) + 1'b1));

  a_r12_pulse_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    hw_deact_o |-> $past(bus_valid && bus_write && (bus_op == 2'd1 || bus_op == 2'd2)));

  a_r7_eoi_drops_one: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_op == 2'd1) |=>
      ($countones(apr_o) == $countones($past(apr_o)) - int'($past(apr_o) != '0)));

  a_r6_ack_adds_at_most_one: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && bus_op == 2'd0) |=>
      ($countones(apr_o) <= $countones($past(apr_o)) + 1));

  a_r5_ack_leaves_active: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && bus_op == 2'd0) |=>
      (bus_rdata == '1 || apr_o != '0));

  a_r11_dir_keeps_apr: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_op == 2'd2) |=> $stable(apr_o));
endmodule

bind vcpu_irq_if vcpu_irq_if_chk #(.ID_W(ID_W), .PRIO_W(PRIO_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_op(bus_op), .bus_rdata(bus_rdata), .apr_o(apr_o),
  .eoi_cnt_o(eoi_cnt_o), .hw_deact_o(hw_deact_o)
);

// File: tb/vcpu_irq_if_tb_top.sv
`timescale 1ns/1ps
module vcpu_irq_if_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [1:0]  bus_op = '0;
  logic [9:0]  bus_wdata = '0;
  logic [9:0]  bus_rdata;
  logic        lr_we = 1'b0;
  logic [1:0]  lr_idx = '0;
  logic [27:0] lr_wdata = '0;
  logic [27:0] lr_rdata;
  logic [31:0] apr_o;
  logic [7:0]  run_prio_o;
  logic [4:0]  eoi_cnt_o;
  logic        split_eoi_o, hw_deact_o;
  logic [9:0]  hw_deact_id_o;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  vcpu_irq_if dut_i (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [27:0] mk_lr(input int vid, input int pid, input int pri,
                                        input bit pend, input bit act, input bit hw);
    return {hw, act, pend, pri[4:0], pid[9:0], vid[9:0]};
  endfunction

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic op(input logic [1:0] code, input bit wr, input int data);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr; bus_op = code; bus_wdata = data[9:0];
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic lr_put(input int idx, input logic [27:0] w);
    @(negedge clk); lr_we = 1'b1; lr_idx = idx[1:0]; lr_wdata = w;
    @(negedge clk); lr_we = 1'b0;
  endtask

  task automatic lr_get(input int idx, output logic [27:0] w);
    lr_idx = idx[1:0]; #0.5; w = lr_rdata;
  endtask

  task automatic t_reset();
    logic [27:0] w;
    do_reset();
    chk(apr_o == 0, "R1 apr", apr_o, 0);
    chk(run_prio_o == 8'hFF, "R1 run_prio", run_prio_o, 255);
    chk(eoi_cnt_o == 0, "R1 cnt", eoi_cnt_o, 0);
    chk(split_eoi_o == 0, "R1 split", split_eoi_o, 0);
    chk(hw_deact_o == 0, "R1 pulse", hw_deact_o, 0);
    for (int i = 0; i < 4; i++) begin
      lr_get(i, w);
      chk(w == 0, "R1 lr zero", w, 0);
    end
  endtask

  task automatic t_lr_rw();
    logic [27:0] w, e;
    e = mk_lr(777, 513, 21, 1, 0, 1);
    lr_put(2, e);
    lr_get(2, w);
    chk(w == e, "R2 lr readback", w, e);
    lr_put(2, 28'd0);
  endtask

  task automatic t_ack_select();
    logic [27:0] w;
    do_reset();
    lr_put(0, mk_lr(40, 0, 6, 1, 0, 0));
    lr_put(1, mk_lr(41, 0, 3, 1, 0, 0));
    lr_put(2, mk_lr(42, 0, 3, 1, 0, 0));
    lr_put(3, mk_lr(43, 0, 0, 0, 0, 0));
    op(2'd0, 0, 0);
    chk(bus_rdata == 41, "R5 tie lowest index", bus_rdata, 41);
    lr_get(1, w);
    chk(w[26:25] == 2'b10, "R6 active not pending", w[26:25], 2);
    chk(apr_o == 32'h8, "R6 apr bit", apr_o, 8);
    chk(run_prio_o == 24, "R4 run prio", run_prio_o, 24);
    op(2'd0, 0, 0);
    chk(bus_rdata == 1023, "R5 spurious equal prio", bus_rdata, 1023);
    chk(apr_o == 32'h8, "R5 spurious no change", apr_o, 8);
    lr_get(2, w);
    chk(w[26:25] == 2'b01, "R5 spurious entry kept", w[26:25], 1);
    op(2'd1, 1, 41);
    chk(apr_o == 0, "R7 drop", apr_o, 0);
    lr_get(1, w);
    chk(w[26:25] == 2'b00, "R7 active cleared", w[26:25], 0);
    chk(eoi_cnt_o == 0, "R7 cnt unchanged", eoi_cnt_o, 0);
    chk(run_prio_o == 8'hFF, "R4 idle", run_prio_o, 255);
  endtask

  task automatic t_nosplit_unmatched();
    logic [27:0] w;
    do_reset();
    lr_put(0, mk_lr(5, 0, 2, 1, 0, 0));
    lr_put(1, mk_lr(6, 0, 1, 1, 0, 0));
    op(2'd0, 0, 0);
    chk(bus_rdata == 6, "R5 best", bus_rdata, 6);
    op(2'd0, 0, 0);
    chk(bus_rdata == 1023, "R5 lower prio blocked", bus_rdata, 1023);
    lr_put(1, mk_lr(6, 0, 1, 0, 0, 0));
    lr_put(0, mk_lr(5, 0, 2, 0, 1, 0));
    op(2'd1, 1, 100);
    chk(eoi_cnt_o == 1 && apr_o == 0, "R8 drop and count", {apr_o, 3'b0, eoi_cnt_o}, 1);
    op(2'd1, 1, 100);
    chk(eoi_cnt_o == 1 && apr_o == 0, "R8 empty no effect", eoi_cnt_o, 1);
    op(2'd2, 1, 5);
    lr_get(0, w);
    chk(w[26] == 1'b1 && hw_deact_o == 0, "R11 dir ignored", w[26], 1);
    op(2'd2, 1, 77);
    chk(eoi_cnt_o == 1, "R11 unmatched dir ignored", eoi_cnt_o, 1);
  endtask

  task automatic t_split();
    logic [27:0] w;
    do_reset();
    op(2'd3, 1, 1);
    op(2'd3, 0, 0);
    chk(bus_rdata == 1 && split_eoi_o, "R3 ctl read", bus_rdata, 1);
    lr_put(0, mk_lr(9, 300, 4, 1, 0, 1));
    op(2'd0, 0, 0);
    chk(bus_rdata == 9, "R5 ack split", bus_rdata, 9);
    op(2'd1, 1, 9);
    lr_get(0, w);
    chk(apr_o == 0 && w[26] == 1'b1, "R9 drop keeps active", w[26], 1);
    chk(hw_deact_o == 0 && eoi_cnt_o == 0, "R9 no pulse no count", hw_deact_o, 0);
    op(2'd2, 1, 9);
    chk(hw_deact_o == 1 && hw_deact_id_o == 300, "R12 pulse id", hw_deact_id_o, 300);
    lr_get(0, w);
    chk(w[26:25] == 0, "R10 deactivated", w[26:25], 0);
    @(negedge clk);
    chk(hw_deact_o == 0, "R12 single cycle", hw_deact_o, 0);
    op(2'd2, 1, 55);
    chk(eoi_cnt_o == 1, "R10 unmatched counts", eoi_cnt_o, 1);
    op(2'd1, 1, 55);
    chk(eoi_cnt_o == 1 && apr_o == 0, "R9 empty no effect", eoi_cnt_o, 1);
    lr_put(1, mk_lr(10, 0, 7, 1, 0, 0));
    op(2'd0, 0, 0);
    chk(apr_o == 32'h80, "R6 apr bit7", apr_o, 128);
    op(2'd1, 1, 200);
    chk(apr_o == 0 && eoi_cnt_o == 1, "R9 unmatched no count", eoi_cnt_o, 1);
  endtask

  task automatic t_hw_nosplit();
    do_reset();
    lr_put(2, mk_lr(20, 513, 1, 1, 0, 1));
    op(2'd0, 0, 0);
    chk(bus_rdata == 20, "R5 ack hw", bus_rdata, 20);
    op(2'd1, 1, 20);
    chk(hw_deact_o == 1 && hw_deact_id_o == 513, "R12 eoi pulse", hw_deact_id_o, 513);
    chk(apr_o == 0, "R7 drop hw", apr_o, 0);
    @(negedge clk);
    chk(hw_deact_o == 0, "R12 pulse ends", hw_deact_o, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_lr_rw();
    t_ack_select();
    t_nosplit_unmatched();
    t_split();
    t_hw_nosplit();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule